// File: doc/BRIEF.md
# Raster Timing Generator with Sprite Mixer

This block turns a system clock into 640x480 raster timing for an analog monitor and paints each visible pixel from two images: a small grayscale background that is stretched four times in each direction to fill the screen, and one rectangular colour sprite placed by its centre point. A toggle flop halves the system clock into a pixel enable. At 50 MHz this gives a 25 MHz pixel rate and a refresh of about 60 frames per second.

Two copies of one four-phase state machine count the pixels of a line and the lines of a frame. Each copy moves through the phases DISPLAY, FRONT, SYNC and BACK. The transitions DISPLAY->FRONT, FRONT->SYNC, SYNC->BACK and BACK->DISPLAY are each taken when the phase counter reaches the last count of its phase on a step. The horizontal machine steps on every pixel enable. The vertical machine steps once per line, at the moment the horizontal machine takes FRONT->SYNC.

Both image stores are synchronous read memories outside the block. The block drives their addresses from the current counters, captures the returned data one system clock later, and registers every output of a pixel in the same stage, so that sync, blank, coordinates and colour stay aligned.

Top module: `vga_sprite_mixer`

## Requirements
- R1: The horizontal machine runs DISPLAY 640, FRONT 16, SYNC 96 and BACK 48 pixels, in that order, for a period of 800 pixels.
- R2: The vertical machine runs DISPLAY 480, FRONT 10, SYNC 2 and BACK 33 lines, in that order, for a period of 525 lines.
- R3: `hsync_n` and `vsync_n` are low exactly while their machine is in SYNC, and high in every other phase.
- R4: The vertical machine takes a step on the same pixel in which the horizontal machine enters SYNC.
- R5: The pixel enable is a flop that toggles on every system clock, so each output pixel is held for two system clocks.
- R6: `blank` is high only when both machines are in DISPLAY. `pix_x` and `pix_y` then carry the counts in raster order, and both are zero while `blank` is low.
- R7: The background address is (y/4)*160 + x/4. The gray byte is sent to all three colour channels.
- R8: The sprite covers columns cx-W/2 to cx+W/2-1 and rows cy-H/2 to cy+H/2-1. Its address is row*W + column, counted from the top-left corner of the sprite. Sprite data is 24 bits, with red in [23:16], green in [15:8] and blue in [7:0].
- R9: Inside the sprite, a sprite word of all zeros shows the background pixel. Any other word is drawn as it is.
- R10: `rgb` is zero whenever `blank` is low.
- R11: The memory addresses follow the current counters. The data returned one system clock later is captured in the output stage together with that pixel's sync, blank and coordinates.
- R12: While `rst` is high, `hsync_n` and `vsync_n` are high, `blank` is low, and `rgb`, `pix_x` and `pix_y` are zero. The first pixel after reset is visible pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice the pixel rate) |
| rst | input | 1 | Synchronous reset, active high |
| spr_cx | input | XW | Sprite centre column |
| spr_cy | input | YW | Sprite centre row |
| bg_addr | output | BG_AW | Background memory address |
| bg_data | input | CH_W | Background gray byte, one clock after its address |
| spr_addr | output | SPR_AW | Sprite memory address |
| spr_data | input | 3*CH_W | Sprite RGB word, one clock after its address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High on visible pixels |
| pix_x | output | XW | Visible column, zero when not visible |
| pix_y | output | YW | Visible row, zero when not visible |
| rgb | output | 3*CH_W | Pixel colour, red in the high byte |

## Verification
The mixer is driven through a table of sprite centres on a scaled-down raster: one centred, one clipped at the top-left corner, one clipped at the bottom-right corner, one near the bottom edge, and one placed fully off the visible area. Comparing these shows the clipping arithmetic, the row and column address order, and whether background pixels leak through or get overwritten. The memory contents put zero words at known sprite addresses, so transparency can be told apart from an opaque sprite or a misaligned data latch. A default-size instance then has its sync pulse widths and line period measured in system clocks, which checks the full-size phase lengths and the halved pixel rate.

// File: rtl/vga_mix_pkg.sv
package vga_mix_pkg;

    typedef enum logic [1:0] {
        PH_DISP  = 2'd0,
        PH_FRONT = 2'd1,
        PH_SYNC  = 2'd2,
        PH_BACK  = 2'd3
    } phase_t;

    function automatic phase_t next_phase(phase_t p);
        unique case (p)
            PH_DISP:  return PH_FRONT;
            PH_FRONT: return PH_SYNC;
            PH_SYNC:  return PH_BACK;
            default:  return PH_DISP;
        endcase
    endfunction

    function automatic int phase_len(phase_t p, int vis, int fp, int sw, int bp);
        unique case (p)
            PH_DISP:  return vis;
            PH_FRONT: return fp;
            PH_SYNC:  return sw;
            default:  return bp;
        endcase
    endfunction

endpackage

// File: rtl/vga_pix_div.sv
module vga_pix_div (
    input  logic clk,
    input  logic rst,
    output logic pix_en
);
    always_ff @(posedge clk) begin
        if (rst) pix_en <= 1'b0;
        else     pix_en <= ~pix_en;
    end

    // R5: the enable never stays high for two clocks in a row
    p_pix_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> !pix_en);
endmodule

// File: rtl/vga_phase_fsm.sv
module vga_phase_fsm
    import vga_mix_pkg::*;
#(
    parameter int VIS = 640,
    parameter int FP  = 16,
    parameter int SW  = 96,
    parameter int BP  = 48,
    parameter int CW  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output phase_t        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic          sync_n_o,
    output logic          enter_sync_o
);
    phase_t        phase_q;
    logic [CW-1:0] cnt_q;
    logic          last_cnt;

    assign last_cnt = (int'(cnt_q) == phase_len(phase_q, VIS, FP, SW, BP) - 1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DISP;
            cnt_q   <= '0;
        end else if (step) begin
            if (last_cnt) begin
                cnt_q   <= '0;
                phase_q <= next_phase(phase_q);
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        phase_o      = phase_q;
        cnt_o        = cnt_q;
        sync_n_o     = 1'b1;
        enter_sync_o = 1'b0;
        unique case (phase_q)
            PH_FRONT: enter_sync_o = step && last_cnt;
            PH_SYNC:  sync_n_o     = 1'b0;
            default:  ;
        endcase
    end

    // R1, R2: phases follow the fixed order
    p_phase_order_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |-> (phase_q == next_phase($past(phase_q))));
    // R1, R2: the counter stays inside the length of its phase
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < phase_len(phase_q, VIS, FP, SW, BP));
endmodule

// File: rtl/vga_pix_mixer.sv
module vga_pix_mixer
    import vga_mix_pkg::*;
#(
    parameter int XW     = 10,
    parameter int YW     = 10,
    parameter int SCALE  = 4,
    parameter int BG_W   = 160,
    parameter int BG_AW  = 15,
    parameter int SPR_W  = 16,
    parameter int SPR_H  = 16,
    parameter int SPR_AW = 8,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  phase_t            h_phase,
    input  logic [XW-1:0]     h_cnt,
    input  logic              h_sync_n,
    input  phase_t            v_phase,
    input  logic [YW-1:0]     v_cnt,
    input  logic              v_sync_n,
    input  logic [XW-1:0]     spr_cx,
    input  logic [YW-1:0]     spr_cy,
    output logic [BG_AW-1:0]  bg_addr,
    input  logic [CH_W-1:0]   bg_data,
    output logic [SPR_AW-1:0] spr_addr,
    input  logic [3*CH_W-1:0] spr_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              blank,
    output logic [XW-1:0]     pix_x,
    output logic [YW-1:0]     pix_y,
    output logic [3*CH_W-1:0] rgb
);
    int   col, row;
    logic in_spr;
    logic visible;

    always_comb begin
        col      = int'(h_cnt) - int'(spr_cx) + SPR_W / 2;
        row      = int'(v_cnt) - int'(spr_cy) + SPR_H / 2;
        in_spr   = (col >= 0) && (col < SPR_W) && (row >= 0) && (row < SPR_H);
        spr_addr = SPR_AW'(row * SPR_W + col);
        bg_addr  = BG_AW'((int'(v_cnt) / SCALE) * BG_W + int'(h_cnt) / SCALE);
        visible  = (h_phase == PH_DISP) && (v_phase == PH_DISP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            blank   <= 1'b0;
            pix_x   <= '0;
            pix_y   <= '0;
            rgb     <= '0;
        end else if (pix_en) begin
            hsync_n <= h_sync_n;
            vsync_n <= v_sync_n;
            blank   <= visible;
            pix_x   <= visible ? h_cnt : '0;
            pix_y   <= visible ? v_cnt : '0;
            if (!visible)
                rgb <= '0;
            else if (in_spr && (spr_data != '0))
                rgb <= spr_data;
            else
                rgb <= {3{bg_data}};
        end
    end
endmodule

// File: rtl/vga_sprite_mixer.sv
module vga_sprite_mixer
    import vga_mix_pkg::*;
#(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SW   = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SW   = 2,
    parameter int V_BP   = 33,
    parameter int SCALE  = 4,
    parameter int SPR_W  = 16,
    parameter int SPR_H  = 16,
    parameter int CH_W   = 8,
    localparam int H_TOT  = H_VIS + H_FP + H_SW + H_BP,
    localparam int V_TOT  = V_VIS + V_FP + V_SW + V_BP,
    localparam int XW     = $clog2(H_TOT),
    localparam int YW     = $clog2(V_TOT),
    localparam int BG_W   = H_VIS / SCALE,
    localparam int BG_H   = V_VIS / SCALE,
    localparam int BG_AW  = $clog2(BG_W * BG_H),
    localparam int SPR_AW = $clog2(SPR_W * SPR_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XW-1:0]     spr_cx,
    input  logic [YW-1:0]     spr_cy,
    output logic [BG_AW-1:0]  bg_addr,
    input  logic [CH_W-1:0]   bg_data,
    output logic [SPR_AW-1:0] spr_addr,
    input  logic [3*CH_W-1:0] spr_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              blank,
    output logic [XW-1:0]     pix_x,
    output logic [YW-1:0]     pix_y,
    output logic [3*CH_W-1:0] rgb
);
    logic          pix_en;
    phase_t        h_phase, v_phase;
    logic [XW-1:0] h_cnt;
    logic [YW-1:0] v_cnt;
    logic          h_sync_n, v_sync_n;
    logic          h_enter, v_enter;

    vga_pix_div u_div (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en)
    );

    vga_phase_fsm #(.VIS(H_VIS), .FP(H_FP), .SW(H_SW), .BP(H_BP), .CW(XW)) u_hfsm (
        .clk          (clk),
        .rst          (rst),
        .step         (pix_en),
        .phase_o      (h_phase),
        .cnt_o        (h_cnt),
        .sync_n_o     (h_sync_n),
        .enter_sync_o (h_enter)
    );

    vga_phase_fsm #(.VIS(V_VIS), .FP(V_FP), .SW(V_SW), .BP(V_BP), .CW(YW)) u_vfsm (
        .clk          (clk),
        .rst          (rst),
        .step         (h_enter),
        .phase_o      (v_phase),
        .cnt_o        (v_cnt),
        .sync_n_o     (v_sync_n),
        .enter_sync_o (v_enter)
    );

    vga_pix_mixer #(
        .XW(XW), .YW(YW), .SCALE(SCALE), .BG_W(BG_W), .BG_AW(BG_AW),
        .SPR_W(SPR_W), .SPR_H(SPR_H), .SPR_AW(SPR_AW), .CH_W(CH_W)
    ) u_mix (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .h_phase  (h_phase),
        .h_cnt    (h_cnt),
        .h_sync_n (h_sync_n),
        .v_phase  (v_phase),
        .v_cnt    (v_cnt),
        .v_sync_n (v_sync_n),
        .spr_cx   (spr_cx),
        .spr_cy   (spr_cy),
        .bg_addr  (bg_addr),
        .bg_data  (bg_data),
        .spr_addr (spr_addr),
        .spr_data (spr_data),
        .hsync_n  (hsync_n),
        .vsync_n  (vsync_n),
        .blank    (blank),
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .rgb      (rgb)
    );

    // R4: the line machine only moves when the pixel machine is entering SYNC
    p_vstep_on_hsync_r4: assert property (@(posedge clk) disable iff (rst)
        ((v_cnt != $past(v_cnt)) || (v_phase != $past(v_phase))) |-> (h_phase == PH_SYNC));
    // R4: a vertical SYNC entry coincides with a horizontal one
    p_vsync_entry_r4: assert property (@(posedge clk) disable iff (rst)
        v_enter |-> h_enter);
    // R3, R6: a sync pulse never overlaps a visible pixel
    p_sync_outside_vis_r3: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> !blank);
endmodule

// File: tb/vga_sprite_mixer_bench.sv
module vga_sprite_mixer_bench;
    localparam int HV = 16, HF = 2, HS = 3, HB = 2;
    localparam int VV = 8,  VF = 1, VS = 2, VB = 2;
    localparam int HT = HV + HF + HS + HB;   // 23
    localparam int VT = VV + VF + VS + VB;   // 13
    localparam int SW = 4, SH = 4;
    localparam int NVEC = 5;
    localparam int VEC [NVEC][2] = '{'{8, 4}, '{0, 0}, '{15, 7}, '{2, 6}, '{20, 12}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // scaled-down instance
    logic [4:0]  s_cx;
    logic [3:0]  s_cy;
    logic [2:0]  s_bg_addr;
    logic [7:0]  s_bg_data;
    logic [3:0]  s_spr_addr;
    logic [23:0] s_spr_data;
    logic        s_hs, s_vs, s_blank;
    logic [4:0]  s_x;
    logic [3:0]  s_y;
    logic [23:0] s_rgb;

    // default-size instance
    logic [14:0] d_bg_addr;
    logic [7:0]  d_spr_addr;
    logic        d_hs, d_vs, d_blank;
    logic [9:0]  d_x, d_y;
    logic [23:0] d_rgb;

    function automatic logic [7:0] bg_fn(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [23:0] spr_fn(int a);
        if (a % 3 == 0) return 24'h0;
        return {8'(a * 16 + 1), 8'(255 - a), 8'h5A};
    endfunction

    always_ff @(posedge clk) begin
        s_bg_data  <= bg_fn(int'(s_bg_addr));
        s_spr_data <= spr_fn(int'(s_spr_addr));
    end

    vga_sprite_mixer #(
        .H_VIS(HV), .H_FP(HF), .H_SW(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SW(VS), .V_BP(VB),
        .SCALE(4), .SPR_W(SW), .SPR_H(SH), .CH_W(8)
    ) u_vga_sprite_mixer (
        .clk(clk), .rst(rst), .spr_cx(s_cx), .spr_cy(s_cy),
        .bg_addr(s_bg_addr), .bg_data(s_bg_data),
        .spr_addr(s_spr_addr), .spr_data(s_spr_data),
        .hsync_n(s_hs), .vsync_n(s_vs), .blank(s_blank),
        .pix_x(s_x), .pix_y(s_y), .rgb(s_rgb)
    );

    vga_sprite_mixer u_full (
        .clk(clk), .rst(rst), .spr_cx(10'd0), .spr_cy(10'd0),
        .bg_addr(d_bg_addr), .bg_data(8'h00),
        .spr_addr(d_spr_addr), .spr_data(24'h0),
        .hsync_n(d_hs), .vsync_n(d_vs), .blank(d_blank),
        .pix_x(d_x), .pix_y(d_y), .rgb(d_rgb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_frame(input int vi, input int cx, input int cy);
        int vis_cnt = 0, pix_bad = 0, xy_bad = 0, dark_bad = 0;
        int hs_low = 0, vs_low = 0, vs_fall = -1, transp = 0;
        int first_bad_act = 0, first_bad_exp = 0;
        logic prev_vs = 1'b1;
        s_cx = 5'(cx);
        s_cy = 4'(cy);
        do_reset();
        for (int i = 0; i < HT * VT; i++) begin
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            if (!s_hs) hs_low++;
            if (!s_vs) vs_low++;
            if (prev_vs && !s_vs && vs_fall < 0) vs_fall = i;
            prev_vs = s_vs;
            if (s_blank) begin
                int ex = vis_cnt % HV, ey = vis_cnt / HV;
                int c = ex - cx + SW / 2, r = ey - cy + SH / 2;
                logic [7:0]  g = bg_fn((ey / 4) * (HV / 4) + ex / 4);
                logic [23:0] e = {g, g, g};
                if (c >= 0 && c < SW && r >= 0 && r < SH) begin
                    logic [23:0] sp = spr_fn(r * SW + c);
                    if (sp != 0) e = sp;
                    else if (s_rgb == {g, g, g}) transp++;
                end
                if (int'(s_x) != ex || int'(s_y) != ey) xy_bad++;
                if (s_rgb != e) begin
                    if (pix_bad == 0) begin
                        first_bad_act = int'(s_rgb);
                        first_bad_exp = int'(e);
                    end
                    pix_bad++;
                end
                vis_cnt++;
            end else begin
                if (s_rgb != 0) dark_bad++;
                if (s_x != 0 || s_y != 0) xy_bad++;
            end
        end
        // R7 R8 R11: colour of every visible pixel
        check(pix_bad == 0, $sformatf("R8 pixel colour vec%0d", vi), first_bad_act, first_bad_exp);
        // R6: raster-order coordinates, zero outside
        check(xy_bad == 0, $sformatf("R6 coordinates vec%0d", vi), xy_bad, 0);
        check(vis_cnt == HV * VV, $sformatf("R6 visible count vec%0d", vi), vis_cnt, HV * VV);
        // R10: dark outside the visible area
        check(dark_bad == 0, $sformatf("R10 dark blank vec%0d", vi), dark_bad, 0);
        // R1 R3: hsync low for HS pixels every line
        check(hs_low == HS * VT, $sformatf("R1 hsync low count vec%0d", vi), hs_low, HS * VT);
        // R2 R3: vsync low for VS lines
        check(vs_low == VS * HT, $sformatf("R2 vsync low count vec%0d", vi), vs_low, VS * HT);
        // R4: vsync falls with the hsync entry of line VV+VF-1
        check(vs_fall == (VV + VF - 1) * HT + HV + HF, $sformatf("R4 vsync fall vec%0d", vi),
              vs_fall, (VV + VF - 1) * HT + HV + HF);
        if (vi == 0)  // R9: six zero words in a 4x4 sprite at addresses 0,3,6,9,12,15
            check(transp == 6, "R9 transparent pixels", transp, 6);
    endtask

    task automatic run_full();
        int t = 0, fall1 = -1, fall2 = -1, low_run = 0, blank_hi = 0;
        logic prev_hs = 1'b1;
        do_reset();
        for (int k = 0; k < 3300; k++) begin
            @(negedge clk);
            t++;
            if (prev_hs && !d_hs) begin
                if (fall1 < 0) fall1 = t;
                else if (fall2 < 0) fall2 = t;
            end
            if (!d_hs && fall2 < 0) low_run++;
            if (d_blank && t <= 1600) blank_hi++;
            prev_hs = d_hs;
        end
        // R1 R5: 96-pixel sync pulse is 192 system clocks
        check(low_run == 192, "R5 hsync width clocks", low_run, 192);
        // R1 R5: 800-pixel line is 1600 system clocks
        check(fall2 - fall1 == 1600, "R1 line period clocks", fall2 - fall1, 1600);
        // R6 R5: 640 visible pixels on line 0
        check(blank_hi == 1280, "R6 visible clocks line 0", blank_hi, 1280);
        // R1: sync begins after 656 pixels
        check(fall1 == 2 + 2 * 656, "R1 first hsync fall", fall1, 2 + 2 * 656);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        s_cx = 5'd8;
        s_cy = 4'd4;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check(s_hs && s_vs && !s_blank, "R12 reset syncs/blank", {s_hs, s_vs, s_blank}, 3'b110);
        check(s_rgb == 0 && s_x == 0 && s_y == 0, "R12 reset data", int'(s_rgb), 0);
        for (int v = 0; v < NVEC; v++)
            run_frame(v, VEC[v][0], VEC[v][1]);
        // R12: first pixel after reset is (0,0) and visible
        do_reset();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(s_blank && s_x == 0 && s_y == 0, "R12 first pixel", {s_blank, s_x, s_y}, 10'h200);
        run_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule